// File: doc/BRIEF.md
# Status Word Flag Update Unit

This block holds a 16-bit processor status word and regenerates its condition flags from ALU results. Each update carries an operation class (arithmetic, logic or bit-control), an operand width (byte or word), the result and the carries out of bit 7 and bit 15. For arithmetic it also takes an add/subtract select and both operand sign bits. The unit writes carry, zero, sign and a shared parity/overflow flag. For bit-control operations it treats the carry flag as a one-bit accumulator.

Software-style access is plain control: either byte of the word can be written on its own, and any single bit can be set or cleared. The current word is always visible on `psw_q`. For interrupt entry and break, the word leaves on a valid/ready save stream. The stack side may stall it as long as it wants: `save_valid` stays high and `save_data` stays frozen until `save_ready` is seen. On return, the word comes back on a restore stream. That stream is accepted only while no save is pending (`restore_ready` low means back-pressure). The ALU update port has no back-pressure and is taken in the cycle `upd_valid` is high.

Every change to the word shows on `psw_q` one clock after the inputs that cause it.

Top module: `psw_flag_unit`

## Requirements
- R1: After reset, `psw_q` is 0x0000, `save_valid` is 0 and `restore_ready` is 1.
- R2: With `upd_word`=0 the flags use `upd_result[7:0]` and carry `upd_c7`. With `upd_word`=1 they use `upd_result[15:0]` and carry `upd_c15`.
- R3: For classes arithmetic (`upd_class`=0) and logic (1), Z (bit 6) is set exactly when the result at the active width is zero. S (bit 7) copies the result's top bit at that width.
- R4: For arithmetic, CY (bit 0) takes the selected carry/borrow. P/V (bit 2) is set only on two's-complement overflow. For an add (`upd_sub`=0) that means equal operand signs with a result sign that differs. For a subtract it means differing operand signs with a result sign unlike the first operand's.
- R5: For logic, P/V is set when the count of one bits in the result at the active width is even and cleared when it is odd. CY is unchanged.
- R6: An update never changes LT (1), IE (3), AC (4), RSS (5) or the high byte. Class 3 changes nothing.
- R7: For bit-control (`upd_class`=2), only CY changes. It becomes `upd_bit` when `upd_bitop`=0 (load). It becomes the AND with `upd_bit` for 1, the OR for 2 and the XOR for 3.
- R8: `wr_en[0]` loads bits 7:0 and `wr_en[1]` loads bits 15:8 from `wr_data`. Bits 11:8 always read 0 and writes to them are ignored. High byte layout: UF at 15, bank select at 14:12.
- R9: `bit_en` sets bit `bit_idx` to `bit_val`. An index of 8 to 11 has no effect.
- R10: A `save_req` pulse with no save pending raises `save_valid` on the next clock, with `save_data` equal to the word before that clock. Both hold until the cycle where `save_valid` and `save_ready` are both high. `restore_ready` is 0 while `save_valid` is 1.
- R11: An accepted restore loads `restore_data` with bits 11:8 forced to 0 and overrides every other source in that cycle. A restore offered while not ready is ignored.
- R12: Within one cycle, a byte write overrides the bit port and flag updates in its half. The bit port overrides a flag update on the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_valid | input | 1 | ALU flag update strobe |
| upd_class | input | 2 | 0 arithmetic, 1 logic, 2 bit-control, 3 none |
| upd_word | input | 1 | 1 word width, 0 byte width |
| upd_sub | input | 1 | Arithmetic was a subtract |
| upd_result | input | 16 | ALU result |
| upd_c7 | input | 1 | Carry/borrow at bit 7 |
| upd_c15 | input | 1 | Carry/borrow at bit 15 |
| upd_sign_a | input | 1 | First operand sign bit |
| upd_sign_b | input | 1 | Second operand sign bit |
| upd_bitop | input | 2 | Bit-control operation on CY |
| upd_bit | input | 1 | Selected bit value for bit-control |
| wr_en | input | 2 | Byte write enables (bit 1 high byte) |
| wr_data | input | 16 | Byte write data |
| bit_en | input | 1 | Single-bit write strobe |
| bit_idx | input | 4 | Bit index |
| bit_val | input | 1 | Bit value |
| psw_q | output | 16 | Current status word |
| save_req | input | 1 | Interrupt or break entry request |
| save_valid | output | 1 | Saved word available |
| save_ready | input | 1 | Stack accepts saved word |
| save_data | output | 16 | Saved word |
| restore_valid | input | 1 | Word offered from stack |
| restore_ready | output | 1 | Restore accepted this cycle |
| restore_data | input | 16 | Word to restore |

## Verification
Some rules are checked by assertions on every cycle. The reserved nibble is checked to read zero. A stalled save is checked to keep its word frozen, and `restore_ready` to stay low while a save is pending. An accepted restore is checked to win over every other source, a lone load-type bit-control operation to land in CY, and word-width updates to set Z. Other behaviour only shows in the bench's scenarios. These are the per-width carry and zero selection, the add and subtract overflow cases, parity on even and odd counts, and the keeping of undefined flags. They also cover priority between writes and updates in one cycle, and the snapshot value a save carries.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W  = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(PSW_W);
  localparam int B_CY  = 0;
  localparam int B_LT  = 1;
  localparam int B_PV  = 2;
  localparam int B_IE  = 3;
  localparam int B_AC  = 4;
  localparam int B_RSS = 5;
  localparam int B_Z   = 6;
  localparam int B_S   = 7;
  localparam logic [PSW_W-1:0] IMPL_MASK = 16'hF0FF;

  typedef enum logic [1:0] {CLS_ARITH, CLS_LOGIC, CLS_BIT, CLS_NONE} op_class_e;
  typedef enum logic [1:0] {BOP_LOAD, BOP_AND, BOP_OR, BOP_XOR} bit_op_e;
endpackage

// File: rtl/psw_flag_gen.sv
module psw_flag_gen
  import psw_pkg::*;
(
  input  logic              upd_valid,
  input  op_class_e         cls,
  input  logic              word,
  input  logic              sub,
  input  logic [PSW_W-1:0]  result,
  input  logic              c7,
  input  logic              c15,
  input  logic              sign_a,
  input  logic              sign_b,
  input  bit_op_e           bop,
  input  logic              bit_in,
  input  logic              cy_now,
  output logic [BYTE_W-1:0] flag_val,
  output logic [BYTE_W-1:0] flag_mask
);
  logic res_msb, res_zero, carry, even_ones, ovf, acc;

  always_comb begin
    res_msb   = word ? result[PSW_W-1] : result[BYTE_W-1];
    res_zero  = word ? (result == '0) : (result[BYTE_W-1:0] == '0);
    carry     = word ? c15 : c7;
    even_ones = word ? ~^result : ~^result[BYTE_W-1:0];
    ovf       = sub ? ((sign_a != sign_b) && (res_msb != sign_a))
                    : ((sign_a == sign_b) && (res_msb != sign_a));
    unique case (bop)
      BOP_LOAD: acc = bit_in;
      BOP_AND:  acc = cy_now & bit_in;
      BOP_OR:   acc = cy_now | bit_in;
      default:  acc = cy_now ^ bit_in;
    endcase
  end

  always_comb begin
    flag_val  = '0;
    flag_mask = '0;
    if (upd_valid) begin
      unique case (cls)
        CLS_ARITH: begin
          flag_mask[B_CY] = 1'b1; flag_val[B_CY] = carry;
          flag_mask[B_PV] = 1'b1; flag_val[B_PV] = ovf;
          flag_mask[B_Z]  = 1'b1; flag_val[B_Z]  = res_zero;
          flag_mask[B_S]  = 1'b1; flag_val[B_S]  = res_msb;
        end
        CLS_LOGIC: begin
          flag_mask[B_PV] = 1'b1; flag_val[B_PV] = even_ones;
          flag_mask[B_Z]  = 1'b1; flag_val[B_Z]  = res_zero;
          flag_mask[B_S]  = 1'b1; flag_val[B_S]  = res_msb;
        end
        CLS_BIT: begin
          flag_mask[B_CY] = 1'b1; flag_val[B_CY] = acc;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/psw_save_port.sv
module psw_save_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         save_req,
  input  logic [W-1:0] snap,
  input  logic         save_ready,
  output logic         save_valid,
  output logic [W-1:0] save_data
);
  logic slot_free;
  assign slot_free = !save_valid || save_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_valid <= 1'b0;
      save_data  <= '0;
    end else if (slot_free) begin
      save_valid <= save_req;
      if (save_req) save_data <= snap;
    end
  end
endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
  import psw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd_valid,
  input  logic [1:0]  upd_class,
  input  logic        upd_word,
  input  logic        upd_sub,
  input  logic [15:0] upd_result,
  input  logic        upd_c7,
  input  logic        upd_c15,
  input  logic        upd_sign_a,
  input  logic        upd_sign_b,
  input  logic [1:0]  upd_bitop,
  input  logic        upd_bit,
  input  logic [1:0]  wr_en,
  input  logic [15:0] wr_data,
  input  logic        bit_en,
  input  logic [3:0]  bit_idx,
  input  logic        bit_val,
  output logic [15:0] psw_q,
  input  logic        save_req,
  output logic        save_valid,
  input  logic        save_ready,
  output logic [15:0] save_data,
  input  logic        restore_valid,
  output logic        restore_ready,
  input  logic [15:0] restore_data
);
  localparam int NBYTES = PSW_W / BYTE_W;

  logic [BYTE_W-1:0] flag_val, flag_mask;
  logic [PSW_W-1:0]  nxt, after_flags, after_bit;
  logic              restore_fire;

  psw_flag_gen u_gen (
    .upd_valid (upd_valid),
    .cls       (op_class_e'(upd_class)),
    .word      (upd_word),
    .sub       (upd_sub),
    .result    (upd_result),
    .c7        (upd_c7),
    .c15       (upd_c15),
    .sign_a    (upd_sign_a),
    .sign_b    (upd_sign_b),
    .bop       (bit_op_e'(upd_bitop)),
    .bit_in    (upd_bit),
    .cy_now    (psw_q[B_CY]),
    .flag_val  (flag_val),
    .flag_mask (flag_mask)
  );

  psw_save_port #(.W(PSW_W)) u_save (
    .clk        (clk),
    .rst_n      (rst_n),
    .save_req   (save_req),
    .snap       (psw_q),
    .save_ready (save_ready),
    .save_valid (save_valid),
    .save_data  (save_data)
  );

  assign restore_ready = !save_valid;
  assign restore_fire  = restore_valid && restore_ready;

  always_comb begin
    after_flags = psw_q;
    after_flags[BYTE_W-1:0] = (psw_q[BYTE_W-1:0] & ~flag_mask) | (flag_val & flag_mask);
    after_bit = after_flags;
    if (bit_en) after_bit[bit_idx] = bit_val;
  end

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_byte
      always_comb
        nxt[g*BYTE_W +: BYTE_W] = wr_en[g] ? wr_data[g*BYTE_W +: BYTE_W]
                                           : after_bit[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            psw_q <= '0;
    else if (restore_fire) psw_q <= restore_data & IMPL_MASK;
    else                   psw_q <= nxt & IMPL_MASK;
  end
endmodule

// File: rtl/psw_flag_unit_chk.sv
module psw_flag_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        upd_valid,
  input logic [1:0]  upd_class,
  input logic        upd_word,
  input logic [15:0] upd_result,
  input logic [1:0]  upd_bitop,
  input logic        upd_bit,
  input logic [1:0]  wr_en,
  input logic        bit_en,
  input logic [15:0] psw_q,
  input logic        save_valid,
  input logic        save_ready,
  input logic [15:0] save_data,
  input logic        restore_valid,
  input logic        restore_ready,
  input logic [15:0] restore_data
);
  logic quiet;
  assign quiet = (wr_en == 2'b00) && !bit_en && !(restore_valid && restore_ready);

  assert_resv_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    psw_q[11:8] == 4'h0);

  assert_save_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    save_valid && !save_ready |=> save_valid && $stable(save_data));

  assert_no_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    save_valid |-> !restore_ready);

  assert_restore_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid && restore_ready |=> psw_q == ($past(restore_data) & 16'hF0FF));

  assert_bit_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_class == 2'd2 && upd_bitop == 2'd0 && quiet
    |=> psw_q[0] == $past(upd_bit));

  assert_word_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_word && (upd_class == 2'd0 || upd_class == 2'd1) && quiet
    |=> psw_q[6] == ($past(upd_result) == 16'h0000));
endmodule

bind psw_flag_unit psw_flag_unit_chk u_chk (.*);

// File: tb/tb_psw_flag_unit.sv
`timescale 1ns/1ps
module tb_psw_flag_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic upd_valid, upd_word, upd_sub, upd_c7, upd_c15, upd_sign_a, upd_sign_b, upd_bit;
  logic [1:0] upd_class, upd_bitop, wr_en;
  logic [15:0] upd_result, wr_data, restore_data, psw_q, save_data;
  logic bit_en, bit_val, save_req, save_valid, save_ready, restore_valid, restore_ready;
  logic [3:0] bit_idx;

  int errors = 0, checks = 0;
  bit done = 0, save_pend = 0;
  logic [15:0] model = 16'h0;
  logic [15:0] exp_q[$];
  string req_q[$];

  always #4 clk = ~clk;

  psw_flag_unit dut (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] predict(logic [15:0] cur);
    logic [15:0] n = cur;
    logic msb, z, cy, ovf;
    msb = upd_word ? upd_result[15] : upd_result[7];
    z   = upd_word ? (upd_result == 0) : (upd_result[7:0] == 0);
    cy  = upd_word ? upd_c15 : upd_c7;
    ovf = upd_sub ? (upd_sign_a != upd_sign_b && msb != upd_sign_a)
                  : (upd_sign_a == upd_sign_b && msb != upd_sign_a);
    if (upd_valid) begin
      if (upd_class == 0) begin n[0] = cy; n[2] = ovf; n[6] = z; n[7] = msb; end
      else if (upd_class == 1) begin
        n[2] = ($countones(upd_word ? upd_result : {8'h0, upd_result[7:0]}) % 2) == 0;
        n[6] = z; n[7] = msb;
      end else if (upd_class == 2) begin
        case (upd_bitop)
          2'd0: n[0] = upd_bit;
          2'd1: n[0] = cur[0] & upd_bit;
          2'd2: n[0] = cur[0] | upd_bit;
          default: n[0] = cur[0] ^ upd_bit;
        endcase
      end
    end
    if (bit_en) n[bit_idx] = bit_val;
    if (wr_en[0]) n[7:0] = wr_data[7:0];
    if (wr_en[1]) n[15:8] = wr_data[15:8];
    if (restore_valid && !save_pend) n = restore_data;
    return n & 16'hF0FF;
  endfunction

  task automatic idle();
    upd_valid = 0; upd_class = 0; upd_word = 0; upd_sub = 0; upd_result = 0;
    upd_c7 = 0; upd_c15 = 0; upd_sign_a = 0; upd_sign_b = 0; upd_bitop = 0; upd_bit = 0;
    wr_en = 0; wr_data = 0; bit_en = 0; bit_idx = 0; bit_val = 0;
    save_req = 0; save_ready = 0; restore_valid = 0; restore_data = 0;
  endtask

  // driver: inputs are already set; predict, clock, push expectation
  task automatic step(string req);
    logic [15:0] e;
    e = predict(model);
    model = e;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    req_q.push_back(req);
    idle();
    @(negedge clk);
  endtask

  task automatic arith(bit w, bit s, logic [15:0] r, bit c7, bit c15, bit sa, bit sb, string req);
    upd_valid = 1; upd_class = 0; upd_word = w; upd_sub = s; upd_result = r;
    upd_c7 = c7; upd_c15 = c15; upd_sign_a = sa; upd_sign_b = sb;
    step(req);
  endtask

  task automatic logic_op(bit w, logic [15:0] r, string req);
    upd_valid = 1; upd_class = 1; upd_word = w; upd_result = r; upd_c7 = 1; upd_c15 = 1;
    step(req);
  endtask

  task automatic bitop(logic [1:0] op, bit b, string req);
    upd_valid = 1; upd_class = 2; upd_bitop = op; upd_bit = b;
    step(req);
  endtask

  task automatic setbit(logic [3:0] i, bit v, string req);
    bit_en = 1; bit_idx = i; bit_val = v;
    step(req);
  endtask

  // monitor: scoreboard comparison
  always @(negedge clk) begin
    if (exp_q.size() > 0) check(req_q.pop_front(), psw_q, exp_q.pop_front());
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] snap;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 psw", psw_q, 16'h0000);
    check("R1 save_valid", {15'h0, save_valid}, 16'h0);
    check("R1 restore_ready", {15'h0, restore_ready}, 16'h1);

    arith(0, 0, 16'h0080, 0, 0, 0, 0, "R4 add overflow byte");
    arith(0, 0, 16'h1200, 1, 0, 1, 1, "R2 byte zero and carry7");
    arith(1, 0, 16'h0000, 1, 0, 0, 0, "R2 word uses carry15");
    arith(1, 0, 16'h8000, 0, 1, 0, 0, "R3 word sign");
    arith(0, 1, 16'h007F, 0, 0, 1, 0, "R4 subtract overflow");
    arith(0, 1, 16'h00FF, 1, 0, 0, 0, "R4 subtract borrow no overflow");
    setbit(4'd0, 1, "R9 set CY");
    logic_op(0, 16'h0003, "R5 even parity keeps CY");
    logic_op(0, 16'hFF07, "R5 odd parity byte");
    logic_op(1, 16'h0100, "R5 odd parity word");
    logic_op(1, 16'h8001, "R5 even parity word sign");
    setbit(4'd3, 1, "R9 set IE");
    setbit(4'd1, 1, "R9 set LT");
    setbit(4'd4, 1, "R9 set AC");
    setbit(4'd5, 1, "R9 set RSS");
    wr_en = 2'b10; wr_data = 16'hA500; step("R8 high byte write");
    arith(0, 0, 16'h0000, 1, 1, 0, 0, "R6 undefined flags kept arith");
    logic_op(1, 16'h0000, "R6 undefined flags kept logic");
    upd_valid = 1; upd_class = 3; upd_result = 16'h8000; upd_c7 = 1; step("R6 class none");
    bitop(2'd0, 0, "R7 load 0");
    bitop(2'd2, 1, "R7 or 1");
    bitop(2'd1, 0, "R7 and 0");
    bitop(2'd3, 1, "R7 xor 1");
    bitop(2'd3, 1, "R7 xor 1 again");
    wr_en = 2'b11; wr_data = 16'hFFFF; step("R8 reserved nibble ignored");
    setbit(4'd9, 0, "R9 reserved index ignored");
    setbit(4'd15, 0, "R9 clear UF");
    wr_en = 2'b01; wr_data = 16'h0000; upd_valid = 1; upd_class = 0; upd_result = 16'h0080;
    step("R12 byte write beats update");
    wr_en = 2'b10; wr_data = 16'h3000; upd_valid = 1; upd_class = 0; upd_result = 16'h0000;
    step("R12 high write with low update");
    bit_en = 1; bit_idx = 4'd0; bit_val = 0; upd_valid = 1; upd_class = 2; upd_bit = 1;
    step("R12 bit port beats update");
    bit_en = 1; bit_idx = 4'd6; bit_val = 1; wr_en = 2'b01; wr_data = 16'h0011;
    step("R12 byte write beats bit port");
    restore_valid = 1; restore_data = 16'h5AC3; wr_en = 2'b11; wr_data = 16'h0000;
    upd_valid = 1; upd_class = 0;
    step("R11 restore wins and masks");

    snap = model;
    save_req = 1; save_ready = 0; step("R10 save leaves word");
    check("R10 save_valid", {15'h0, save_valid}, 16'h1);
    check("R10 save_data", save_data, snap);
    check("R10 restore_ready low", {15'h0, restore_ready}, 16'h0);
    save_pend = 1;
    restore_valid = 1; restore_data = 16'h0000; bit_en = 1; bit_idx = 4'd7; bit_val = 0;
    step("R11 restore ignored while not ready");
    check("R10 hold valid", {15'h0, save_valid}, 16'h1);
    check("R10 hold data", save_data, snap);
    save_ready = 1; save_pend = 0; step("R10 save accepted");
    check("R10 valid drops", {15'h0, save_valid}, 16'h0);
    check("R10 restore_ready back", {15'h0, restore_ready}, 16'h1);
    restore_valid = 1; restore_data = 16'h0F0F; step("R11 restore after save");

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule